// File: doc/BRIEF.md
# Float Compare and Predicate Combine Unit

This unit takes two single-precision operands, applies per-operand sign modifiers, compares them under a 4-bit condition selector and merges the boolean outcome with an incoming predicate bit through a 2-bit logic selector. It is purely combinational and sits in the execute stage of a shader-style pipeline. The pipeline registers operands before the unit and latches the two predicates after it.

Each operand can have its sign cleared, its sign inverted, or both, before the comparison. The comparison covers the ordered relations, their unordered counterparts (true whenever a NaN is present), and the two NaN-presence tests. Two predicates come out. The primary one merges the comparison result with the incoming bit. The secondary one merges the inverted comparison result with the same incoming bit, so that a following branch or select can use both senses from one evaluation.

The parameter `DENORM_AS_ZERO` picks a variant at elaboration. In the default variant (0), subnormal inputs are compared by their exact value. In the other variant, subnormal inputs are treated as signed zeros before the comparison.

Top module: `fcmp_pred_unit`

## Requirements
- R1: When neither operand is NaN, condition codes 1, 2, 3, 4, 5 and 6 yield true exactly when a<b, a==b, a<=b, a>b, a!=b and a>=b hold, respectively.
- R2: A NaN is a value whose exponent field (bits 30:23) is all ones and whose fraction (bits 22:0) is nonzero. When either operand is NaN, codes 1 to 6 yield false.
- R3: Codes 9, 10, 11, 12 and 14 yield true when a<b, a==b, a<=b, a>b and a>=b hold, respectively, or when either operand is NaN.
- R4: Code 7 yields true exactly when neither operand is NaN. Code 8 yields true exactly when at least one operand is NaN.
- R5: Codes 0, 13 and 15 always yield a false comparison result.
- R6: +0 and -0 compare equal. Infinities lie outside all finite values. With DENORM_AS_ZERO=0, subnormals are ordered by their exact value.
- R7: For each operand, the clear-sign modifier (bit 31 forced to 0) is applied first and the invert-sign modifier (bit 31 flipped) second, both before the comparison. A NaN remains NaN under either modifier.
- R8: pred_o = cmp op pred_in_i, where cmp is the comparison result and op is selected by lop_i: 0 gives AND, 1 gives OR, 2 gives XOR, and 3 behaves as AND.
- R9: pred_n_o = (NOT cmp) op pred_in_i, using the same op as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, single-precision bit pattern |
| b_i | input | 32 | Second operand, single-precision bit pattern |
| neg_a_i | input | 1 | Invert the sign of operand a |
| abs_a_i | input | 1 | Clear the sign of operand a |
| neg_b_i | input | 1 | Invert the sign of operand b |
| abs_b_i | input | 1 | Clear the sign of operand b |
| cmp_code_i | input | 4 | Condition selector (see R1–R5) |
| lop_i | input | 2 | Combine selector (see R8) |
| pred_in_i | input | 1 | Incoming predicate bit |
| pred_o | output | 1 | Primary predicate |
| pred_n_o | output | 1 | Secondary predicate built from the inverted comparison |

## Verification
The unit holds no state, so a wrong intermediate signal shows at the predicates as soon as the inputs settle, in the same cycle. The internal signals that can go wrong are the NaN flags, the zero flag and the less/equal/greater triple. A stuck NaN flag flips every unordered or NUM/NAN result for the affected operand pairs. A broken zero or sign path shows up only for signed zeros, subnormals of opposite sign and negated operands. For this reason the sweep crosses every condition code with NaN, infinity, signed-zero and subnormal operands, together with varying modifiers and combine selectors.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   localparam int unsigned COND_W = 4;
   localparam int unsigned LOP_W  = 2;

   typedef enum logic [COND_W-1:0] {
      CND_NEVER0 = 4'd0,  CND_LT  = 4'd1,  CND_EQ  = 4'd2,  CND_LE  = 4'd3,
      CND_GT     = 4'd4,  CND_NE  = 4'd5,  CND_GE  = 4'd6,  CND_NUM = 4'd7,
      CND_NAN    = 4'd8,  CND_LTU = 4'd9,  CND_EQU = 4'd10, CND_LEU = 4'd11,
      CND_GTU    = 4'd12, CND_RSV = 4'd13, CND_GEU = 4'd14, CND_NEVERF = 4'd15
   } cond_e;

   typedef enum logic [LOP_W-1:0] {
      LOP_AND = 2'd0, LOP_OR = 2'd1, LOP_XOR = 2'd2, LOP_ALT = 2'd3
   } lop_e;
endpackage

// File: rtl/fcmp_operand.sv
module fcmp_operand #(
   parameter int unsigned EXP_W          = 8,
   parameter int unsigned MAN_W          = 23,
   parameter bit          DENORM_AS_ZERO = 1'b0,
   localparam int unsigned FP_W          = EXP_W + MAN_W + 1
) (
   input  logic [FP_W-1:0] x_i,
   input  logic            neg_i,
   input  logic            abs_i,
   output logic [FP_W-1:0] y_o,
   output logic            nan_o,
   output logic            zero_o
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             sign_f;
   logic [MAN_W-1:0] man_eff;

   assign exp_f  = x_i[FP_W-2 -: EXP_W];
   assign man_f  = x_i[MAN_W-1:0];
   assign sign_f = (x_i[FP_W-1] & ~abs_i) ^ neg_i;

   generate
      if (DENORM_AS_ZERO) begin : g_daz
         assign man_eff = (exp_f == '0) ? '0 : man_f;
      end else begin : g_exact
         assign man_eff = man_f;
      end
   endgenerate

   assign y_o    = {sign_f, exp_f, man_eff};
   assign nan_o  = (&exp_f) && (man_f != '0);
   assign zero_o = (exp_f == '0) && (man_eff == '0);

   always_comb begin
      if (!$isunknown({x_i, neg_i, abs_i})) begin
         AST_NAN_KEPT: assert (!nan_o || ((&y_o[FP_W-2 -: EXP_W]) && (y_o[MAN_W-1:0] != '0)))
            else $error("modifier destroyed NaN"); // R7
      end
   end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned FP_W = EXP_W + MAN_W + 1
) (
   input  logic [FP_W-1:0] a_i,
   input  logic [FP_W-1:0] b_i,
   input  logic            a_nan_i,
   input  logic            b_nan_i,
   input  logic            a_zero_i,
   input  logic            b_zero_i,
   output logic            lt_o,
   output logic            eq_o,
   output logic            gt_o,
   output logic            unord_o
);
   logic [FP_W-2:0] mag_a, mag_b;
   logic            both_zero, eq_raw, lt_raw;

   assign mag_a     = a_i[FP_W-2:0];
   assign mag_b     = b_i[FP_W-2:0];
   assign both_zero = a_zero_i & b_zero_i;
   assign eq_raw    = both_zero | (a_i == b_i);

   always_comb begin
      if (both_zero)                      lt_raw = 1'b0;
      else if (a_i[FP_W-1] != b_i[FP_W-1]) lt_raw = a_i[FP_W-1];
      else if (!a_i[FP_W-1])              lt_raw = mag_a < mag_b;
      else                                lt_raw = mag_a > mag_b;
   end

   assign unord_o = a_nan_i | b_nan_i;
   assign lt_o    = lt_raw & ~unord_o;
   assign eq_o    = eq_raw & ~unord_o;
   assign gt_o    = ~lt_raw & ~eq_raw & ~unord_o;

   always_comb begin
      if (!$isunknown({a_i, b_i, a_nan_i, b_nan_i, a_zero_i, b_zero_i})) begin
         AST_ONE_RELATION: assert (unord_o || $onehot({lt_o, eq_o, gt_o}))
            else $error("ordered pair without single relation"); // R1
         AST_SIGNED_ZERO: assert (!(a_zero_i && b_zero_i) || eq_o)
            else $error("zeros not equal"); // R6
      end
   end
endmodule

// File: rtl/fcmp_cond_sel.sv
module fcmp_cond_sel
   import fcmp_pkg::*;
(
   input  logic [COND_W-1:0] code_i,
   input  logic              lt_i,
   input  logic              eq_i,
   input  logic              gt_i,
   input  logic              unord_i,
   output logic              res_o
);
   logic rel_hit, reserved;

   assign rel_hit  = |(code_i[2:0] & {gt_i, eq_i, lt_i});
   assign reserved = (code_i == CND_NEVER0) || (code_i == CND_RSV) || (code_i == CND_NEVERF);
   assign res_o    = ~reserved & (rel_hit | (code_i[3] & unord_i));

   always_comb begin
      if (!$isunknown({code_i, lt_i, eq_i, gt_i, unord_i})) begin
         AST_ORDERED_NAN: assert (!(unord_i && code_i >= CND_LT && code_i <= CND_GE) || !res_o)
            else $error("ordered code true on NaN"); // R2
         AST_UNORD_NAN: assert (!(unord_i && code_i >= CND_LTU && code_i <= CND_GEU
                                  && code_i != CND_RSV) || res_o)
            else $error("unordered code false on NaN"); // R3
         AST_RESERVED_FALSE: assert (!reserved || !res_o)
            else $error("reserved code true"); // R5
      end
   end
endmodule

// File: rtl/fcmp_pred_combine.sv
module fcmp_pred_combine
   import fcmp_pkg::*;
(
   input  logic             res_i,
   input  logic             pred_in_i,
   input  logic [LOP_W-1:0] lop_i,
   output logic             pred_o,
   output logic             pred_n_o
);
   function automatic logic merge(input logic r, input logic p, input logic [LOP_W-1:0] op);
      case (op)
         LOP_OR:  return r | p;
         LOP_XOR: return r ^ p;
         default: return r & p;
      endcase
   endfunction

   assign pred_o   = merge(res_i, pred_in_i, lop_i);
   assign pred_n_o = merge(~res_i, pred_in_i, lop_i);
endmodule

// File: rtl/fcmp_pred_unit.sv
module fcmp_pred_unit
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W          = 8,
   parameter int unsigned MAN_W          = 23,
   parameter bit          DENORM_AS_ZERO = 1'b0,
   localparam int unsigned FP_W          = EXP_W + MAN_W + 1
) (
   input  logic [FP_W-1:0]   a_i,
   input  logic [FP_W-1:0]   b_i,
   input  logic              neg_a_i,
   input  logic              abs_a_i,
   input  logic              neg_b_i,
   input  logic              abs_b_i,
   input  logic [COND_W-1:0] cmp_code_i,
   input  logic [LOP_W-1:0]  lop_i,
   input  logic              pred_in_i,
   output logic              pred_o,
   output logic              pred_n_o
);
   generate
      if (EXP_W < 2 || MAN_W < 1) begin : g_bad_fmt
         $error("fcmp_pred_unit: EXP_W must be >= 2 and MAN_W >= 1");
      end
   endgenerate

   logic [FP_W-1:0] a_m, b_m;
   logic            a_nan, b_nan, a_zero, b_zero;
   logic            lt, eq, gt, unord, cmp_res;

   fcmp_operand #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DENORM_AS_ZERO(DENORM_AS_ZERO)) u_opa (
      .x_i(a_i), .neg_i(neg_a_i), .abs_i(abs_a_i),
      .y_o(a_m), .nan_o(a_nan), .zero_o(a_zero));

   fcmp_operand #(.EXP_W(EXP_W), .MAN_W(MAN_W), .DENORM_AS_ZERO(DENORM_AS_ZERO)) u_opb (
      .x_i(b_i), .neg_i(neg_b_i), .abs_i(abs_b_i),
      .y_o(b_m), .nan_o(b_nan), .zero_o(b_zero));

   fcmp_relation #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
      .a_i(a_m), .b_i(b_m), .a_nan_i(a_nan), .b_nan_i(b_nan),
      .a_zero_i(a_zero), .b_zero_i(b_zero),
      .lt_o(lt), .eq_o(eq), .gt_o(gt), .unord_o(unord));

   fcmp_cond_sel u_sel (
      .code_i(cmp_code_i), .lt_i(lt), .eq_i(eq), .gt_i(gt), .unord_i(unord),
      .res_o(cmp_res));

   fcmp_pred_combine u_comb (
      .res_i(cmp_res), .pred_in_i(pred_in_i), .lop_i(lop_i),
      .pred_o(pred_o), .pred_n_o(pred_n_o));

   always_comb begin
      if (!$isunknown({lop_i, pred_o, pred_n_o})) begin
         AST_XOR_COMPLEMENT: assert (lop_i != LOP_XOR || (pred_o != pred_n_o))
            else $error("xor predicates not complementary"); // R9
      end
   end
endmodule

// File: tb/fcmp_pred_unit_tb.sv
module fcmp_pred_unit_tb;
   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic        na, aa, nb, ab, pin;
   logic [3:0]  code;
   logic [1:0]  lop;
   logic        p, pn;
   int          total = 0, bad = 0;
   bit          drv_done = 1'b0;

   typedef struct { logic ep; logic epn; string tag; } exp_t;
   exp_t sbq[$];

   always #10 clk = ~clk;

   fcmp_pred_unit u_dut (
      .a_i(a), .b_i(b), .neg_a_i(na), .abs_a_i(aa), .neg_b_i(nb), .abs_b_i(ab),
      .cmp_code_i(code), .lop_i(lop), .pred_in_i(pin), .pred_o(p), .pred_n_o(pn));

   function automatic logic [31:0] corner(input int k);
      case (k)
         0: return 32'h0000_0000; 1: return 32'h8000_0000; 2: return 32'h3f80_0000;
         3: return 32'hbf80_0000; 4: return 32'h4000_0000; 5: return 32'h7f80_0000;
         6: return 32'hff80_0000; 7: return 32'h7fc0_0000; 8: return 32'hff80_0001;
         9: return 32'h0000_0001; 10: return 32'h8000_0001; default: return 32'hc020_0000;
      endcase
   endfunction

   function automatic logic is_nan(input logic [31:0] x);
      return (x[30:23] == 8'hff) && (x[22:0] != 0);
   endfunction

   function automatic logic [32:0] order_key(input logic [31:0] x);
      return x[31] ? (33'h0_8000_0000 - {2'b0, x[30:0]}) : (33'h0_8000_0000 + {2'b0, x[30:0]});
   endfunction

   function automatic logic ref_cmp(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
      logic u, l, e, g;
      u = is_nan(x) || is_nan(y);
      l = order_key(x) < order_key(y);
      e = order_key(x) == order_key(y);
      g = order_key(x) > order_key(y);
      case (c)
         1: return !u && l;       2: return !u && e;       3: return !u && (l || e);
         4: return !u && g;       5: return !u && !e;      6: return !u && (g || e);
         7: return !u;            8: return u;             9: return u || l;
         10: return u || e;       11: return u || l || e;  12: return u || g;
         14: return u || g || e;  default: return 1'b0;
      endcase
   endfunction

   function automatic logic ref_op(input logic r, input logic q, input logic [1:0] o);
      if (o == 2'd1) return r | q;
      if (o == 2'd2) return r ^ q;
      return r & q;
   endfunction

   function automatic string pick_tag(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c);
      logic u;
      u = is_nan(x) || is_nan(y);
      if (c >= 1 && c <= 6) begin
         if (u) return "R2";
         if (x[30:0] == 0 || y[30:0] == 0 || x[30:23] == 0 || y[30:23] == 0) return "R6";
         return "R1";
      end
      if (c == 7 || c == 8) return "R4";
      if (c >= 9 && c != 13 && c != 15) return "R3";
      return "R5";
   endfunction

   task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic [3:0] mods,
                        input logic [3:0] c, input logic [1:0] o, input logic q, input string t);
      logic [31:0] xm, ym;
      exp_t e;
      @(negedge clk);
      a = x; b = y; na = mods[0]; aa = mods[1]; nb = mods[2]; ab = mods[3];
      code = c; lop = o; pin = q;
      xm = mods[1] ? {1'b0, x[30:0]} : x;  xm[31] = xm[31] ^ mods[0];
      ym = mods[3] ? {1'b0, y[30:0]} : y;  ym[31] = ym[31] ^ mods[2];
      e.ep  = ref_op(ref_cmp(xm, ym, c), q, o);
      e.epn = ref_op(!ref_cmp(xm, ym, c), q, o);
      e.tag = (t != "") ? t : pick_tag(xm, ym, c);
      sbq.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            total += 2;
            if (p !== e.ep) begin
               bad++;
               $display("FAIL %s R8 pred_o actual=%b expected=%b (a=%h b=%h code=%0d lop=%0d)",
                        e.tag, p, e.ep, a, b, code, lop);
            end
            if (pn !== e.epn) begin
               bad++;
               $display("FAIL %s R9 pred_n_o actual=%b expected=%b (a=%h b=%h code=%0d lop=%0d)",
                        e.tag, pn, e.epn, a, b, code, lop);
            end
         end
      end
   end

   initial begin : driver
      a = '0; b = '0; na = 0; aa = 0; nb = 0; ab = 0; code = '0; lop = '0; pin = 0;
      // idle inputs: reserved code 0 with AND gives both predicates low (R5)
      drive(32'h0, 32'h0, 4'h0, 4'd0, 2'd0, 1'b0, "R5");
      // modifiers: -|+1| equals -1; |-2| equals +2; -|NaN| still NaN (R7)
      drive(32'h3f80_0000, 32'hbf80_0000, 4'b0011, 4'd2, 2'd0, 1'b1, "R7");
      drive(32'hc000_0000, 32'h4000_0000, 4'b0010, 4'd2, 2'd0, 1'b1, "R7");
      drive(32'h7fc0_0000, 32'h3f80_0000, 4'b0011, 4'd8, 2'd0, 1'b1, "R7");
      // combine selector 3 acts as AND (R8)
      drive(32'h3f80_0000, 32'h4000_0000, 4'h0, 4'd1, 2'd3, 1'b0, "R8");
      drive(32'h3f80_0000, 32'h4000_0000, 4'h0, 4'd1, 2'd3, 1'b1, "R8");
      for (int i = 0; i < 12; i++)
         for (int j = 0; j < 12; j++)
            for (int c = 0; c < 16; c++)
               drive(corner(i), corner(j), 4'((i * 3 + j * 5 + c) % 16) & 4'((c % 3 == 0) ? 4'h0 : 4'hf),
                     4'(c), 2'((i + j + c) % 4), 1'((i ^ c) & 1), "");
      repeat (3) @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin : finish_ctl
      fork
         wait (drv_done && sbq.size() == 0);
         begin
            repeat (20000) @(posedge clk);
            bad++; total++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule